// File: doc/BRIEF.md
# Nested Five-Level Interrupt Arbiter

This block sits between a set of peripheral interrupt lines and a small processor core. It gathers requests from three groups. The first is core exceptions that cannot be masked. The second is debug events that can be masked. The third is one software request at the lowest level, plus a bank of peripheral sources, each of which has its own enable, its own priority level and a choice of edge or level sensing. Each cycle it picks one winner and presents it to the core with a vector address, and it holds that choice until the core acknowledges it.

The core reports its current mask level. Only requests at or above that level are forwarded, except for the unmaskable exceptions. This lets a higher-level request reach the core while a lower-level handler is running, which is how nesting works. Vector addresses are computed from a base input that can be relocated. One fast-interrupt slot can be steered to any source number. When its source wins its level, the slot replaces the table vector with a dedicated vector. A combinational wake output tells clock control that something enabled is pending, whatever the mask.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` and `wake` are low and no request is presented.
- R2: Source numbers are as follows: exceptions 0 to 3, debug events 4 to 6, the software request 7, and peripheral i is 8+i. The issued vector is `vec_base` + 2 × source number, using the base value at the moment of issue.
- R3: Peripheral i's 2-bit field `src_lvl[2i+1:2i]` selects its level: 0 is L0, 1 is L1, and 2 or 3 is L2. A peripheral whose `src_en` bit is low is never issued.
- R4: Levels are coded as LP=0, L0=1, L1=2, L2=3, L3=4. A maskable request is forwarded only when its code is at least `core_mask`. Mask values 5 to 7 block every maskable source.
- R5: Any `exc_req` bit is forwarded at level code 4 regardless of `core_mask`.
- R6: Debug event k is forwarded at level code 4 only when `dbg_en[k]` is high and `core_mask` is at most 4.
- R7: The highest forwarded level wins. Among sources at that level, the lowest source number wins.
- R8: When `fast_en` is high and source `fast_src` is forwarded at the winning level, it wins over the other sources at that level. Its vector is `fast_vec`, and `irq_fast` is high.
- R9: A request is issued on the clock edge after it is forwarded. `irq_vec`, `irq_lvl` and `irq_fast` then hold steady while `irq_valid` is high and `irq_ack` is low. `irq_ack` drops `irq_valid` on the next edge.
- R10: A peripheral with its `src_edge` bit high becomes pending on a rising edge of its request line. Acknowledging that source clears the pending bit, but a new rising edge in the acknowledge cycle keeps it pending.
- R11: A peripheral with its `src_edge` bit low is pending exactly while its request line is high, and acknowledging it does not clear it.
- R12: `wake` is high whenever an exception, an enabled debug event, the software request or an enabled pending peripheral is present, regardless of `core_mask`.
- R13: While `core_mask` is raised for a running handler, a request at a higher level is still issued (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_req | input | NSRC | Peripheral request lines |
| src_en | input | NSRC | Peripheral enables |
| src_edge | input | NSRC | 1 = edge-sensed, 0 = level-sensed |
| src_lvl | input | 2*NSRC | Per-peripheral level fields |
| exc_req | input | 4 | Unmaskable exception requests |
| dbg_req | input | 3 | Maskable debug event requests |
| dbg_en | input | 3 | Debug event enables |
| sw_req | input | 1 | Lowest-level software request |
| core_mask | input | 3 | Core's current acceptance level code |
| vec_base | input | VW | Vector table base |
| fast_en | input | 1 | Fast slot enable |
| fast_src | input | NW | Source number steered to the fast slot |
| fast_vec | input | VW | Fast slot vector |
| irq_ack | input | 1 | Core acknowledge pulse |
| irq_valid | output | 1 | Request presented to the core |
| irq_vec | output | VW | Vector address of the presented request |
| irq_lvl | output | 3 | Level code of the presented request |
| irq_fast | output | 1 | Presented request came from the fast slot |
| wake | output | 1 | Something enabled is pending |

## Verification
Two things can fall in the same clock edge: an acknowledge that clears an edge-sensed peripheral's pending bit, and a fresh rising edge on that same request line. The bench provokes this by lowering the line while the request is held, then raising it in exactly the cycle that carries `irq_ack`. It then expects the same vector to be re-issued two edges later. A second acknowledge without a new edge must leave `irq_valid` and `wake` low.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int VW   = 16,
  localparam int NTOT = 8 + NSRC,
  localparam int NW   = $clog2(NTOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_edge,
  input  logic [2*NSRC-1:0] src_lvl,
  input  logic [3:0]      exc_req,
  input  logic [2:0]      dbg_req,
  input  logic [2:0]      dbg_en,
  input  logic            sw_req,
  input  logic [2:0]      core_mask,
  input  logic [VW-1:0]   vec_base,
  input  logic            fast_en,
  input  logic [NW-1:0]   fast_src,
  input  logic [VW-1:0]   fast_vec,
  input  logic            irq_ack,
  output logic            irq_valid,
  output logic [VW-1:0]   irq_vec,
  output logic [2:0]      irq_lvl,
  output logic            irq_fast,
  output logic            wake
);

  logic [NSRC-1:0] prev_q, epend_q, pend, clr;
  logic [NTOT-1:0] fwd;
  logic [2:0]      lv [NTOT];
  logic [NW-1:0]   irq_num, best_num;
  logic [2:0]      best_lvl;
  logic            found, fast_hit;

  assign pend = (src_edge & epend_q) | (~src_edge & src_req);
  assign wake = (|exc_req) | (|(dbg_req & dbg_en)) | sw_req | (|(pend & src_en));

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      lv[i]  = 3'd4;
      fwd[i] = exc_req[i];
    end
    for (int i = 0; i < 3; i++) begin
      lv[4+i]  = 3'd4;
      fwd[4+i] = dbg_req[i] & dbg_en[i] & (core_mask <= 3'd4);
    end
    lv[7]  = 3'd0;
    fwd[7] = sw_req & (core_mask == 3'd0);
    for (int j = 0; j < NSRC; j++) begin
      case (src_lvl[2*j +: 2])
        2'd0:    lv[8+j] = 3'd1;
        2'd1:    lv[8+j] = 3'd2;
        default: lv[8+j] = 3'd3;
      endcase
      fwd[8+j] = pend[j] & src_en[j] & (lv[8+j] >= core_mask);
    end
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = 3'd0;
    best_num = '0;
    for (int i = 0; i < NTOT; i++) begin
      if (fwd[i] && (!found || lv[i] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = lv[i];
        best_num = NW'(i);
      end
    end
    fast_hit = 1'b0;
    if (fast_en && int'(fast_src) < NTOT)
      fast_hit = fwd[fast_src] && (lv[fast_src] == best_lvl);
  end

  always_comb
    for (int j = 0; j < NSRC; j++)
      clr[j] = irq_valid && irq_ack && (irq_num == NW'(8 + j));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      epend_q   <= '0;
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_lvl   <= '0;
      irq_fast  <= 1'b0;
      irq_num   <= '0;
    end else begin
      prev_q  <= src_req;
      epend_q <= (epend_q & ~clr) | (src_req & ~prev_q & src_edge);
      if (irq_valid) begin
        if (irq_ack) irq_valid <= 1'b0;
      end else if (found) begin
        irq_valid <= 1'b1;
        irq_lvl   <= best_lvl;
        irq_fast  <= fast_hit;
        irq_num   <= fast_hit ? fast_src : best_num;
        irq_vec   <= fast_hit ? fast_vec : vec_base + VW'({best_num, 1'b0});
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vec) && $stable(irq_lvl) && $stable(irq_fast));
  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid);
  assert_unmaskable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_req) && !irq_valid |=> irq_valid && irq_lvl == 3'd4);
  assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> (irq_num < NW'(4)) || (irq_lvl >= $past(core_mask)));
  assert_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(wake));
  assert_fast_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && irq_fast |-> irq_vec == $past(fast_vec));

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int VW = 16;

  logic clk = 0, rst_n = 0;
  logic [7:0] src_req = 0, src_en = 0, src_edge = 0;
  logic [15:0] src_lvl = 0;
  logic [3:0] exc_req = 0;
  logic [2:0] dbg_req = 0, dbg_en = 0, core_mask = 0;
  logic sw_req = 0, fast_en = 0, irq_ack = 0;
  logic [3:0] fast_src = 0;
  logic [15:0] vec_base = 16'h0100, fast_vec = 16'h0A00;
  logic irq_valid, irq_fast, wake;
  logic [15:0] irq_vec;
  logic [2:0] irq_lvl;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .VW(VW)) u0 (
    .clk, .rst_n, .src_req, .src_en, .src_edge, .src_lvl, .exc_req, .dbg_req,
    .dbg_en, .sw_req, .core_mask, .vec_base, .fast_en, .fast_src, .fast_vec,
    .irq_ack, .irq_valid, .irq_vec, .irq_lvl, .irq_fast, .wake);

  typedef struct packed {
    logic [7:0] req; logic [7:0] en; logic [15:0] lvl; logic [2:0] mask;
    logic [3:0] exc; logic [2:0] dbg; logic [2:0] den; logic sw; logic fen;
    logic [3:0] fsrc; logic ev; logic [15:0] evec; logic [2:0] elvl; logic efast;
    logic [3:0] rq;
  } row_t;

  localparam int NROW = 15;
  localparam row_t TBL [NROW] = '{
    '{8'h01, 8'hFF, 16'h0000, 3'd0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b1, 16'h0110, 3'd1, 1'b0, 4'd3},  // R3
    '{8'h06, 8'hFF, 16'h0010, 3'd0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b1, 16'h0114, 3'd2, 1'b0, 4'd7},  // R7
    '{8'h0C, 8'hFF, 16'h00A0, 3'd0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b1, 16'h0114, 3'd3, 1'b0, 4'd7},  // R7
    '{8'h01, 8'hFF, 16'h0000, 3'd2, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd4},  // R4
    '{8'h01, 8'hFE, 16'h0000, 3'd0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd3},  // R3
    '{8'h00, 8'h00, 16'h0000, 3'd0, 4'h0, 3'b000, 3'b000, 1'b1, 1'b0, 4'd0, 1'b1, 16'h010E, 3'd0, 1'b0, 4'd4},  // R4
    '{8'h00, 8'h00, 16'h0000, 3'd1, 4'h0, 3'b000, 3'b000, 1'b1, 1'b0, 4'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd4},  // R4
    '{8'h00, 8'h00, 16'h0000, 3'd7, 4'h4, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b1, 16'h0104, 3'd4, 1'b0, 4'd5},  // R5
    '{8'h01, 8'hFF, 16'h0002, 3'd4, 4'h0, 3'b010, 3'b111, 1'b0, 1'b0, 4'd0, 1'b1, 16'h010A, 3'd4, 1'b0, 4'd6},  // R6
    '{8'h00, 8'h00, 16'h0000, 3'd5, 4'h0, 3'b010, 3'b111, 1'b0, 1'b0, 4'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 4'd6},  // R6
    '{8'h00, 8'h00, 16'h0000, 3'd0, 4'h0, 3'b001, 3'b000, 1'b1, 1'b0, 4'd0, 1'b1, 16'h010E, 3'd0, 1'b0, 4'd6},  // R6
    '{8'h03, 8'hFF, 16'h0005, 3'd0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b1, 4'd9, 1'b1, 16'h0A00, 3'd2, 1'b1, 4'd8},  // R8
    '{8'h03, 8'hFF, 16'h0002, 3'd0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b1, 4'd9, 1'b1, 16'h0110, 3'd3, 1'b0, 4'd8},  // R8
    '{8'h00, 8'h00, 16'h0000, 3'd0, 4'h0, 3'b000, 3'b000, 1'b1, 1'b1, 4'd7, 1'b1, 16'h0A00, 3'd0, 1'b1, 4'd8},  // R8
    '{8'h00, 8'h00, 16'h0000, 3'd7, 4'h9, 3'b000, 3'b000, 1'b0, 1'b0, 4'd0, 1'b1, 16'h0100, 3'd4, 1'b0, 4'd2}   // R2 R7
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    src_req = 0; src_en = 0; src_edge = 0; src_lvl = 0; exc_req = 0;
    dbg_req = 0; dbg_en = 0; sw_req = 0; core_mask = 0; fast_en = 0; fast_src = 0;
    if (irq_valid) begin irq_ack = 1; cyc(1); irq_ack = 0; end
    cyc(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 valid", 32'(irq_valid), 0);
    chk("R1 wake", 32'(wake), 0);
    rst_n = 1;
    cyc(2);
    chk("R1 valid after release", 32'(irq_valid), 0);

    for (int r = 0; r < NROW; r++) begin
      src_req = TBL[r].req; src_en = TBL[r].en; src_lvl = TBL[r].lvl;
      core_mask = TBL[r].mask; exc_req = TBL[r].exc; dbg_req = TBL[r].dbg;
      dbg_en = TBL[r].den; sw_req = TBL[r].sw; fast_en = TBL[r].fen; fast_src = TBL[r].fsrc;
      cyc(3);
      chk($sformatf("R%0d row %0d valid", TBL[r].rq, r), 32'(irq_valid), 32'(TBL[r].ev));
      if (TBL[r].ev) begin
        chk($sformatf("R%0d row %0d vec", TBL[r].rq, r), 32'(irq_vec), 32'(TBL[r].evec));
        chk($sformatf("R%0d row %0d lvl", TBL[r].rq, r), 32'(irq_lvl), 32'(TBL[r].elvl));
        chk($sformatf("R%0d row %0d fast", TBL[r].rq, r), 32'(irq_fast), 32'(TBL[r].efast));
      end
      clear_all();
    end

    // R9 hold until ack, then R11 level source re-issues
    src_en = 8'hFF; src_req = 8'h01;
    cyc(3);
    chk("R9 first issue", 32'(irq_vec), 32'h0110);
    src_req = 8'h03; src_lvl = 16'h0008;
    cyc(2);
    chk("R9 held vec", 32'(irq_vec), 32'h0110);
    chk("R9 held lvl", 32'(irq_lvl), 1);
    irq_ack = 1; cyc(1); irq_ack = 0;
    chk("R9 dropped after ack", 32'(irq_valid), 0);
    cyc(1);
    chk("R9 next winner", 32'(irq_vec), 32'h0112);
    src_req = 8'h01; src_lvl = 0;
    irq_ack = 1; cyc(1); irq_ack = 0; cyc(1);
    chk("R11 level source not cleared", 32'(irq_vec), 32'h0110);
    clear_all();

    // R13 nesting: mask raised for L0 handler, L1 request still issues
    src_en = 8'hFF; src_req = 8'h01;
    cyc(3);
    core_mask = 3'd2; irq_ack = 1; cyc(1); irq_ack = 0;
    cyc(2);
    chk("R4 lower level blocked by raised mask", 32'(irq_valid), 0);
    src_req = 8'h05; src_lvl = 16'h0010;
    cyc(3);
    chk("R13 nested issue", 32'(irq_vec), 32'h0114);
    chk("R13 nested lvl", 32'(irq_lvl), 2);
    clear_all();

    // R12 wake independent of mask
    src_en = 8'h01; src_req = 8'h01; core_mask = 3'd7;
    cyc(3);
    chk("R12 wake under full mask", 32'(wake), 1);
    chk("R12 no issue under full mask", 32'(irq_valid), 0);
    src_en = 8'h00; cyc(1);
    chk("R12 wake low when disabled", 32'(wake), 0);
    clear_all();

    // R2 relocated base
    vec_base = 16'h2000; src_en = 8'hFF; src_req = 8'h08;
    cyc(3);
    chk("R2 relocated vector", 32'(irq_vec), 32'h2016);
    clear_all();
    vec_base = 16'h0100;

    // R10 edge pending, ack and new edge in the same cycle
    src_en = 8'hFF; src_edge = 8'h01; src_req = 8'h01;
    cyc(1); src_req = 8'h00;
    cyc(2);
    chk("R10 edge captured", 32'(irq_vec), 32'h0110);
    chk("R10 edge valid", 32'(irq_valid), 1);
    irq_ack = 1; src_req = 8'h01; cyc(1); irq_ack = 0;
    cyc(1);
    chk("R10 reissue after ack with new edge", 32'(irq_valid), 1);
    chk("R10 reissue vec", 32'(irq_vec), 32'h0110);
    irq_ack = 1; cyc(1); irq_ack = 0;
    cyc(2);
    chk("R10 cleared by ack", 32'(irq_valid), 0);
    chk("R10 wake after clear", 32'(wake), 0);
    clear_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule